// File: doc/BRIEF.md
# Quadrature NCO Tuner

This block is the first digital stage of a direct-sampling receiver. It accepts one real sample per clock from a 10-bit converter that delivers offset-binary codes, and turns that stream into complex baseband. The sample is first re-coded to two's complement. A phase-accumulating oscillator produces cosine and negated sine references. Two signed multipliers mix the sample with these references, and each product is rounded and clamped back to the input precision.

The tuning word comes from an outside control path and may change at any clock. A change alters the phase increment from the next edge onward, and the running phase is kept. Decimation and filtering follow this block and are not part of it. A sample-valid flag travels through a delay line that matches the datapath, so downstream logic can tell which output samples are real.

Top module: `tuner_top`

## Requirements
- R1: The input code is offset binary. The signed sample equals the code minus 512, so code 512 gives 0, code 0 gives -512 and code 1023 gives +511. This is done by inverting bit 9.
- R2: A 26-bit phase accumulator resets to 0. On every clock edge it adds the tuning word, modulo 2^26, whether or not the sample is valid.
- R3: A new tuning word is used from the very next edge. The accumulated phase is not reset when the word changes.
- R4: The table index is accumulator bits [25:16], written k. The table value is round(511·sin(2πk/1024)), with halves rounded away from zero. I is mixed with cos (index k+256 mod 1024) and Q is mixed with -sin (index k).
- R5: Each product x·c is rounded as (x·c + 256) >>> 9 and then clamped to [-512, 511]. With x = -512 at phase 0, I = -511. With x = 511 at phase 0, I = 510 and Q = 0.
- R6: A sample presented before edge n pairs with the phase held just before edge n. Its I and Q appear after edge n+1, which is a latency of 2 clocks. valid_o equals valid_i delayed by 2 clocks.
- R7: While rst_ni is low, i_o, q_o and valid_o are 0, and the accumulator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_i | input | 10 | Converter sample, offset binary |
| valid_i | input | 1 | Sample-valid flag |
| tw_i | input | 26 | Phase increment per clock |
| i_o | output | 10 | In-phase output, signed |
| q_o | output | 10 | Quadrature output, signed |
| valid_o | output | 1 | valid_i delayed by 2 clocks |

## Verification
I, Q and valid are due exactly two edges after their inputs are applied. The phase that a sample pairs with is the accumulator value before the edge that captures the sample. Inputs change on the falling edge. The bench advances a requirement-derived model on each rising edge and compares the outputs on the next falling edge, so every comparison lands in the cycle the result is due. Literal checks at quarter-turn tuning, at the input extremes and at midscale pin down the table values and the rounding without relying on that model.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
  localparam int unsigned DW  = 10;          // sample and reference width
  localparam int unsigned PW  = 26;          // phase accumulator width
  localparam int unsigned LW  = 10;          // table index width
  localparam int unsigned QB  = LW - 2;      // quarter-wave index width
  localparam int unsigned QN  = 1 << QB;     // quarter-wave span
  localparam int unsigned SH  = DW - 1;      // product rescale
  localparam int unsigned LAT = 2;           // datapath latency
  localparam int          AMP = (1 << (DW - 1)) - 1;

  // quarter-wave sine, QN+1 points including the peak
  function automatic logic [(QN+1)*DW-1:0] quarter_tab();
    logic [(QN+1)*DW-1:0] t;
    real r;
    t = '0;
    for (int j = 0; j <= int'(QN); j++) begin
      r = real'(AMP) * $sin(2.0 * 3.14159265358979323846 * real'(j) / real'(4 * QN));
      t[j*DW +: DW] = DW'($rtoi(r + 0.5));
    end
    return t;
  endfunction
endpackage

// File: rtl/tuner_fmt.sv
module tuner_fmt
  import tuner_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DW-1:0]        code_i,
  output logic signed [DW-1:0] x_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) x_o <= '0;
    else         x_o <= {~code_i[DW-1], code_i[DW-2:0]};
  end
endmodule

// File: rtl/tuner_nco.sv
module tuner_nco
  import tuner_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PW-1:0]        tw_i,
  output logic signed [DW-1:0] cos_o,
  output logic signed [DW-1:0] nsin_o
);
  localparam logic [(QN+1)*DW-1:0] TAB = quarter_tab();

  logic [PW-1:0] phase_q;
  logic [LW-1:0] idx_s, idx_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + tw_i;
  end

  assign idx_s = phase_q[PW-1 -: LW];
  assign idx_c = idx_s + LW'(QN);

  function automatic logic signed [DW-1:0] lookup(input logic [LW-1:0] p);
    logic [QB:0]          j;
    logic signed [DW-1:0] v;
    j = p[LW-2] ? ((QB+1)'(QN) - {1'b0, p[QB-1:0]}) : {1'b0, p[QB-1:0]};
    v = TAB[int'(j)*DW +: DW];
    return p[LW-1] ? -v : v;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cos_o  <= '0;
      nsin_o <= '0;
    end else begin
      cos_o  <= lookup(idx_c);
      nsin_o <= -lookup(idx_s);
    end
  end
endmodule

// File: rtl/tuner_mix.sv
module tuner_mix
  import tuner_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] c_i,
  output logic signed [DW-1:0] y_o
);
  localparam int unsigned PWD = 2 * DW + 1;
  localparam logic signed [PWD-1:0] HI  = PWD'(AMP);
  localparam logic signed [PWD-1:0] LO  = -HI - PWD'(1);
  localparam logic signed [PWD-1:0] RND = PWD'(1) <<< (SH - 1);

  logic signed [2*DW-1:0] prod;
  logic signed [PWD-1:0]  rnd, scl;
  logic signed [DW-1:0]   sat;

  assign prod = x_i * c_i;
  assign rnd  = {prod[2*DW-1], prod} + RND;
  assign scl  = rnd >>> SH;

  always_comb begin
    if (scl > HI)      sat = HI[DW-1:0];
    else if (scl < LO) sat = LO[DW-1:0];
    else               sat = scl[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_o <= '0;
    else         y_o <= sat;
  end
endmodule

// File: rtl/tuner_top.sv
module tuner_top
  import tuner_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DW-1:0]        adc_i,
  input  logic                 valid_i,
  input  logic [PW-1:0]        tw_i,
  output logic signed [DW-1:0] i_o,
  output logic signed [DW-1:0] q_o,
  output logic                 valid_o
);
  logic signed [DW-1:0] x_s, cos_s, nsin_s;
  logic [LAT-1:0]       vld_q;

  tuner_fmt u_fmt (.clk_i, .rst_ni, .code_i(adc_i), .x_o(x_s));
  tuner_nco u_nco (.clk_i, .rst_ni, .tw_i, .cos_o(cos_s), .nsin_o(nsin_s));
  tuner_mix u_mix_i (.clk_i, .rst_ni, .x_i(x_s), .c_i(cos_s),  .y_o(i_o));
  tuner_mix u_mix_q (.clk_i, .rst_ni, .x_i(x_s), .c_i(nsin_s), .y_o(q_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LAT-2:0], valid_i};
  end
  assign valid_o = vld_q[LAT-1];
endmodule

// File: rtl/tuner_chk.sv
module tuner_chk
  import tuner_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [DW-1:0]        adc_i,
  input logic                 valid_i,
  input logic [PW-1:0]        tw_i,
  input logic [PW-1:0]        phase_i,
  input logic signed [DW-1:0] i_o,
  input logic signed [DW-1:0] q_o,
  input logic                 valid_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2) |-> (valid_o == $past(valid_i, 2)));  // R6

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1) |-> (phase_i == $past(phase_i) + $past(tw_i)));  // R2

  AST_MIDSCALE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && $past(adc_i, 2) == DW'(1 << (DW-1))) |-> (i_o == '0 && q_o == '0));  // R1

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |=> (valid_o == 1'b0 && i_o == '0 && q_o == '0));  // R7
endmodule

bind tuner_top tuner_chk u_chk (
  .clk_i, .rst_ni, .adc_i, .valid_i, .tw_i,
  .phase_i(u_nco.phase_q),
  .i_o, .q_o, .valid_o
);

// File: tb/test_tuner_top.sv
module test_tuner_top;
  localparam int DW = 10;
  localparam int PW = 26;
  localparam int NV = 12;
  // {adc code, tuning word}
  localparam logic [DW+PW-1:0] VEC [NV] = '{
    {10'd512,  26'd0},        {10'd1023, 26'd1 << 20},  {10'd0,    26'd3 << 21},
    {10'd700,  26'h3FFFFFF},  {10'd100,  26'd12345678}, {10'd900,  26'd1 << 25},
    {10'd513,  26'd7},        {10'd511,  26'h2AAAAAA},  {10'd300,  26'd1 << 16},
    {10'd1000, 26'h1555555},  {10'd2,    26'd0},        {10'd800,  26'd999999}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] adc = '0;
  logic [PW-1:0] tw = '0;
  logic vin = 1'b0;
  logic signed [DW-1:0] i_o, q_o;
  logic valid_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tuner_top i_tuner_top (
    .clk_i(clk), .rst_ni(rst_n), .adc_i(adc), .valid_i(vin), .tw_i(tw),
    .i_o(i_o), .q_o(q_o), .valid_o(valid_o)
  );

  function automatic int lut_sin(int k);
    real r;
    r = 511.0 * $sin(2.0 * 3.14159265358979323846 * real'(k) / 1024.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic int mix(int x, int c);
    int r;
    r = (x * c + 256) >>> 9;
    if (r > 511) r = 511;
    if (r < -512) r = -512;
    return r;
  endfunction

  // requirement model
  logic [PW-1:0] m_ph;
  int m_x1, m_c1, m_s1, m_i, m_q;
  logic m_v1, m_v2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= '0; m_x1 <= 0; m_c1 <= 0; m_s1 <= 0; m_i <= 0; m_q <= 0;
      m_v1 <= 1'b0; m_v2 <= 1'b0;
    end else begin
      m_x1 <= int'(adc) - 512;
      m_c1 <= lut_sin((int'(m_ph[PW-1 -: 10]) + 256) % 1024);
      m_s1 <= -lut_sin(int'(m_ph[PW-1 -: 10]));
      m_i  <= mix(m_x1, m_c1);
      m_q  <= mix(m_x1, m_s1);
      m_v1 <= vin;
      m_v2 <= m_v1;
      m_ph <= m_ph + tw;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(logic [DW-1:0] a, logic [PW-1:0] t, logic v, string tag);
    adc = a; tw = t; vin = v;
    @(posedge clk); @(negedge clk);
    chk({tag, " I"}, int'(i_o), m_i);
    chk({tag, " Q"}, int'(q_o), m_q);
    chk({tag, " valid"}, int'(valid_o), int'(m_v2));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R7 reset I", int'(i_o), 0);
    chk("R7 reset Q", int'(q_o), 0);
    chk("R7 reset valid", int'(valid_o), 0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R2 R4 R5 R6 vector walk with varied words, including wrap
    for (int n = 0; n < 3 * NV; n++)
      step(VEC[n % NV][DW+PW-1 -: DW], VEC[n % NV][PW-1:0], n[0] ^ n[2], "R2 R4 R6 vector");

    // R3: word changes mid-run, phase kept
    for (int n = 0; n < 8; n++) step(10'd1010, 26'd1 << (18 + n), 1'b1, "R3 retune");

    // R4 R5 quarter-turn tuning, literal values
    do_reset();
    for (int n = 0; n < 9; n++) begin
      step(10'd1023, 26'd1 << 24, 1'b1, "R4 quarter");
      if (n >= 1) begin
        chk("R4 quarter I literal", int'(i_o), (n-1)%4 == 0 ? 510 : (n-1)%4 == 2 ? -510 : 0);
        chk("R4 quarter Q literal", int'(q_o), (n-1)%4 == 1 ? -510 : (n-1)%4 == 3 ? 510 : 0);
      end
    end

    // R1 R5 extremes at phase 0
    do_reset();
    step(10'd0, 26'd0, 1'b1, "R1 neg");
    step(10'd0, 26'd0, 1'b0, "R1 neg");
    chk("R5 min input I", int'(i_o), -511);
    chk("R5 min input Q", int'(q_o), 0);
    step(10'd512, 26'd0, 1'b1, "R1 mid");
    chk("R5 min input Q held", int'(q_o), 0);
    step(10'd1023, 26'd0, 1'b0, "R1 mid");
    chk("R1 midscale I", int'(i_o), 0);
    chk("R1 midscale Q", int'(q_o), 0);
    step(10'd1023, 26'd0, 1'b0, "R1 pos");
    chk("R5 max input I", int'(i_o), 510);
    chk("R6 valid delayed", int'(valid_o), 0);
    finish_run();
  end
endmodule